// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block owns the three outgoing message slots of a CAN-style controller. Software fills a slot with a message payload (identifier, control bits and data, treated here as one opaque word) and an 8-bit local priority, then hands the slot over by clearing its empty flag. Whenever the transmitter is idle and the bus reports that arbitration may begin, the block chooses one pending slot and offers it to the bus side through a start/done/error handshake.

The numerically smallest priority wins; equal priorities go to the lower slot index. A failed transmission leaves the slot pending, and the choice is made again at the next arbitration, so a more urgent message loaded in the meantime goes first. Software can ask to withdraw a pending message. The request is granted at once for a slot that is waiting. For a slot already on the wire it is held until the attempt ends. A granted withdrawal frees the slot and sets an abort-acknowledge flag, so an interrupt handler can tell a withdrawn message from a sent one. Each slot has a level interrupt: its empty flag gated by a per-slot enable.

Top module: `tx_buf_sched`

## Requirements
- R1: After reset every slot reads empty (empty_o all ones), abort_ack_o is all zeros and tx_start_o is 0.
- R2: A load (ld_valid_i with slot ld_idx_i) stores ld_prio_i and ld_payload_i only if that slot is empty; a load aimed at a pending or transmitting slot is ignored, and the payload later presented for that slot is unchanged.
- R3: A release_i bit for an empty slot clears that slot's empty flag and its abort-acknowledge flag on the next clock edge; a release bit for a slot that is not empty has no effect.
- R4: When the transmitter is idle, bus_idle_i is 1 and at least one slot is pending without an abort request, tx_start_o goes to 1 for exactly one cycle after that clock edge, with tx_idx_o naming the slot of smallest priority value (on equal values the lowest index) and tx_payload_o carrying that slot's payload.
- R5: No new tx_start_o pulse is issued while a transmission is outstanding (between a start and the next tx_done_i or tx_err_i) or while bus_idle_i is 0.
- R6: tx_done_i during a transmission sets the active slot's empty flag, keeps its abort-acknowledge flag at 0 and drops any abort request held for it.
- R7: tx_err_i during a transmission ends it with the slot still pending; selection among all pending slots runs again at the next arbitration.
- R8: An abort_i bit for a pending slot that is not being transmitted sets that slot's empty and abort-acknowledge flags on the second clock edge after the request is sampled, and the slot is not started in between; an abort_i bit for an empty slot is ignored.
- R9: An abort_i bit for the transmitting slot is held: if the attempt ends with tx_done_i the slot completes as a normal send (acknowledge 0); if it ends with tx_err_i the abort is granted on the following edge (empty and acknowledge both 1) and the slot is not restarted.
- R10: irq_o[i] equals empty_o[i] AND irq_en_i[i] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | Load strobe for one slot |
| ld_idx_i | input | IDX_W | Slot addressed by the load |
| ld_prio_i | input | PRIO_W | Local priority, smaller value is more urgent |
| ld_payload_i | input | PAYLOAD_W | Message payload to store |
| release_i | input | NUM_BUF | Per-slot hand-over strobe (clears empty flag) |
| abort_i | input | NUM_BUF | Per-slot withdrawal request strobe |
| irq_en_i | input | NUM_BUF | Per-slot interrupt enable |
| bus_idle_i | input | 1 | Bus is free for arbitration |
| tx_done_i | input | 1 | Bus side reports successful send |
| tx_err_i | input | 1 | Bus side reports failed attempt |
| tx_start_o | output | 1 | One-cycle start of a transmission |
| tx_idx_o | output | IDX_W | Slot being transmitted |
| tx_payload_o | output | PAYLOAD_W | Payload of the slot being transmitted |
| empty_o | output | NUM_BUF | Per-slot empty flags |
| abort_ack_o | output | NUM_BUF | Per-slot abort-acknowledge flags |
| irq_o | output | NUM_BUF | Per-slot transmit interrupt |

## Verification
The bench builds the block with three slots, 8-bit priorities and a 16-bit payload. The narrow payload keeps every stored message readable in a failure line, while the full priority width lets ties, a late urgent load and value 0 all be posed. Three slots are enough to reach a tie between two pending slots and an error retry that loses to a newly released slot. They also reach a withdrawal held across a transmission that ends in success in one case and in error in another.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  typedef enum logic {
    CTRL_IDLE = 1'b0,
    CTRL_XMIT = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/tx_slot.sv
module tx_slot #(
  parameter int PRIO_W    = 8,
  parameter int PAYLOAD_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PRIO_W-1:0]    wr_prio,
  input  logic [PAYLOAD_W-1:0] wr_payload,
  input  logic                 rel_req,
  input  logic                 abt_req,
  input  logic                 active,
  input  logic                 done_hit,
  output logic                 empty_o,
  output logic                 ack_o,
  output logic                 elig_o,
  output logic [PRIO_W-1:0]    prio_o,
  output logic [PAYLOAD_W-1:0] payload_o
);
  logic empty_q, empty_n;
  logic ack_q, ack_n;
  logic rq_q, rq_n;
  logic data_en;
  logic [PRIO_W-1:0]    prio_q;
  logic [PAYLOAD_W-1:0] payload_q;

  assign data_en = wr_en & empty_q;

  always_comb begin
    empty_n = empty_q;
    ack_n   = ack_q;
    rq_n    = rq_q;
    if (rel_req && empty_q) begin
      empty_n = 1'b0;
      ack_n   = 1'b0;
    end
    if (abt_req && !empty_q) rq_n = 1'b1;
    if (done_hit) begin
      empty_n = 1'b1;
      ack_n   = 1'b0;
      rq_n    = 1'b0;
    end else if (rq_q && !empty_q && !active) begin
      empty_n = 1'b1;
      ack_n   = 1'b1;
      rq_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      ack_q   <= 1'b0;
      rq_q    <= 1'b0;
    end else begin
      empty_q <= empty_n;
      ack_q   <= ack_n;
      rq_q    <= rq_n;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      prio_q    <= wr_prio;
      payload_q <= wr_payload;
    end
  end

  assign empty_o   = empty_q;
  assign ack_o     = ack_q;
  assign elig_o    = ~empty_q & ~rq_q;
  assign prio_o    = prio_q;
  assign payload_o = payload_q;

  AST_ACK_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> empty_q); // R8
  AST_ACTIVE_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !empty_q); // R4
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> (empty_q && !ack_q)); // R6
  AST_NO_ACK_ON_AIR: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> !ack_q); // R9
endmodule

// File: rtl/tx_prio_select.sv
module tx_prio_select #(
  parameter int NUM_BUF = 3,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_BUF-1:0]        elig,
  input  logic [NUM_BUF*PRIO_W-1:0] prio_flat,
  output logic                      sel_valid,
  output logic [IDX_W-1:0]          sel_idx
);
  logic [PRIO_W-1:0] best;

  // Strict less-than keeps the earlier (lower) index on equal priorities.
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    best      = '1;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (elig[i] && (!sel_valid || (prio_flat[i*PRIO_W +: PRIO_W] < best))) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
        best      = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/tx_sched_ctrl.sv
module tx_sched_ctrl
  import tx_sched_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_idle,
  input  logic             tx_done,
  input  logic             tx_err,
  input  logic             sel_valid,
  input  logic [IDX_W-1:0] sel_idx,
  output logic             busy_o,
  output logic [IDX_W-1:0] act_o,
  output logic             start_o
);
  ctrl_state_e      state_q, state_n;
  logic [IDX_W-1:0] act_q, act_n;
  logic             start_q, start_n;
  logic             act_en;

  always_comb begin
    state_n = state_q;
    act_n   = act_q;
    act_en  = 1'b0;
    start_n = 1'b0;
    unique case (state_q)
      CTRL_IDLE: begin
        if (bus_idle && sel_valid) begin
          state_n = CTRL_XMIT;
          act_n   = sel_idx;
          act_en  = 1'b1;
          start_n = 1'b1;
        end
      end
      CTRL_XMIT: begin
        if (tx_done || tx_err) state_n = CTRL_IDLE;
      end
      default: state_n = CTRL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTRL_IDLE;
      act_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_n;
      start_q <= start_n;
      if (act_en) act_q <= act_n;
    end
  end

  assign busy_o  = (state_q == CTRL_XMIT);
  assign act_o   = act_q;
  assign start_o = start_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R4
  AST_START_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(bus_idle)); // R5
  AST_START_IN_XMIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (state_q == CTRL_XMIT)); // R5
  AST_END_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CTRL_XMIT) && (tx_done || tx_err)) |=> (!start_q && state_q == CTRL_IDLE)); // R7
endmodule

// File: rtl/tx_buf_sched.sv
module tx_buf_sched #(
  parameter int NUM_BUF   = 3,
  parameter int PRIO_W    = 8,
  parameter int PAYLOAD_W = 64,
  localparam int IDX_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid_i,
  input  logic [IDX_W-1:0]     ld_idx_i,
  input  logic [PRIO_W-1:0]    ld_prio_i,
  input  logic [PAYLOAD_W-1:0] ld_payload_i,
  input  logic [NUM_BUF-1:0]   release_i,
  input  logic [NUM_BUF-1:0]   abort_i,
  input  logic [NUM_BUF-1:0]   irq_en_i,
  input  logic                 bus_idle_i,
  input  logic                 tx_done_i,
  input  logic                 tx_err_i,
  output logic                 tx_start_o,
  output logic [IDX_W-1:0]     tx_idx_o,
  output logic [PAYLOAD_W-1:0] tx_payload_o,
  output logic [NUM_BUF-1:0]   empty_o,
  output logic [NUM_BUF-1:0]   abort_ack_o,
  output logic [NUM_BUF-1:0]   irq_o
);
  logic [1:0]                rst_sync_q;
  logic                      rst_core_n;
  logic [NUM_BUF-1:0]        elig;
  logic [NUM_BUF*PRIO_W-1:0] prio_flat;
  logic [PAYLOAD_W-1:0]      pl_arr [NUM_BUF];
  logic                      sel_valid;
  logic [IDX_W-1:0]          sel_idx;
  logic                      busy;
  logic [IDX_W-1:0]          act_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    logic [PRIO_W-1:0] prio_w;
    logic              hit;
    assign hit = busy && (act_idx == IDX_W'(g));

    tx_slot #(
      .PRIO_W    (PRIO_W),
      .PAYLOAD_W (PAYLOAD_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .wr_en      (ld_valid_i && (ld_idx_i == IDX_W'(g))),
      .wr_prio    (ld_prio_i),
      .wr_payload (ld_payload_i),
      .rel_req    (release_i[g]),
      .abt_req    (abort_i[g]),
      .active     (hit),
      .done_hit   (hit && tx_done_i),
      .empty_o    (empty_o[g]),
      .ack_o      (abort_ack_o[g]),
      .elig_o     (elig[g]),
      .prio_o     (prio_w),
      .payload_o  (pl_arr[g])
    );
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_w;
  end

  tx_prio_select #(
    .NUM_BUF (NUM_BUF),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) u_select (
    .elig      (elig),
    .prio_flat (prio_flat),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx)
  );

  tx_sched_ctrl #(
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_idle  (bus_idle_i),
    .tx_done   (tx_done_i),
    .tx_err    (tx_err_i),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .busy_o    (busy),
    .act_o     (act_idx),
    .start_o   (tx_start_o)
  );

  assign tx_idx_o     = act_idx;
  assign tx_payload_o = pl_arr[act_idx];
  assign irq_o        = empty_o & irq_en_i;

  AST_START_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_start_o |-> !empty_o[act_idx]); // R4
endmodule

// File: tb/tx_buf_sched_tb.sv
module tx_buf_sched_tb;
  localparam int NB = 3;
  localparam int PW = 8;
  localparam int DW = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [PW-1:0] ld_prio = '0;
  logic [DW-1:0] ld_payload = '0;
  logic [NB-1:0] rel = '0;
  logic [NB-1:0] abt = '0;
  logic [NB-1:0] irq_en = 3'b101;
  logic          bus_idle = 1'b0;
  logic          tx_done = 1'b0;
  logic          tx_err = 1'b0;
  logic          tx_start;
  logic [IW-1:0] tx_idx;
  logic [DW-1:0] tx_payload;
  logic [NB-1:0] empty, ack, irq;

  tx_buf_sched #(.NUM_BUF(NB), .PRIO_W(PW), .PAYLOAD_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid_i(ld_valid), .ld_idx_i(ld_idx),
    .ld_prio_i(ld_prio), .ld_payload_i(ld_payload), .release_i(rel),
    .abort_i(abt), .irq_en_i(irq_en), .bus_idle_i(bus_idle),
    .tx_done_i(tx_done), .tx_err_i(tx_err), .tx_start_o(tx_start),
    .tx_idx_o(tx_idx), .tx_payload_o(tx_payload), .empty_o(empty),
    .abort_ack_o(ack), .irq_o(irq));

  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int n_starts = 0;
  int cycles = 0;
  bit cmp_en = 1'b0;

  task automatic cmp(string tag, logic [31:0] a, logic [31:0] e);
    n_vec++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  // Behavioural reference model
  logic [NB-1:0] m_empty, m_ack, m_rq;
  int            m_pr [NB];
  logic [DW-1:0] m_pl [NB];
  bit            m_busy, m_start;
  int            m_act;

  task automatic model_step();
    logic [NB-1:0] ne = m_empty, na = m_ack, nr = m_rq;
    int best = -1;
    if (ld_valid && m_empty[ld_idx]) begin
      m_pr[ld_idx] = int'(ld_prio);
      m_pl[ld_idx] = ld_payload;
    end
    for (int i = 0; i < NB; i++) begin
      bit on_air = m_busy && (m_act == i);
      if (rel[i] && m_empty[i]) begin ne[i] = 0; na[i] = 0; end
      if (abt[i] && !m_empty[i]) nr[i] = 1;
      if (on_air && tx_done) begin ne[i] = 1; na[i] = 0; nr[i] = 0; end
      else if (m_rq[i] && !m_empty[i] && !on_air) begin ne[i] = 1; na[i] = 1; nr[i] = 0; end
    end
    m_start = 0;
    if (m_busy) begin
      if (tx_done || tx_err) m_busy = 0;
    end else if (bus_idle) begin
      for (int i = 0; i < NB; i++)
        if (!m_empty[i] && !m_rq[i] && (best < 0 || m_pr[i] < m_pr[best])) best = i;
      if (best >= 0) begin m_busy = 1; m_act = best; m_start = 1; end
    end
    m_empty = ne; m_ack = na; m_rq = nr;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_empty = '1; m_ack = '0; m_rq = '0; m_busy = 0; m_start = 0; m_act = 0;
    end else begin
      model_step();
    end
    #2;
    cycles++;
    if (tx_start === 1'b1) n_starts++;
    if (cmp_en) begin
      cmp("R3/R6/R8 empty flags", 32'(empty), 32'(m_empty));
      cmp("R8/R9 abort ack flags", 32'(ack), 32'(m_ack));
      cmp("R10 irq", 32'(irq), 32'(m_empty & irq_en));
      cmp("R4/R5 tx_start", 32'(tx_start), 32'(m_start));
      if (m_start) begin
        cmp("R4 tx_idx", 32'(tx_idx), 32'(m_act));
        cmp("R2/R4 tx_payload", 32'(tx_payload), 32'(m_pl[m_act]));
      end
    end
  end

  // Stimulus helpers: called at a falling edge, return at the next one
  task automatic load(int idx, int prio, logic [DW-1:0] pl);
    ld_valid = 1; ld_idx = IW'(idx); ld_prio = PW'(prio); ld_payload = pl;
    @(negedge clk);
    ld_valid = 0;
  endtask
  task automatic do_release(logic [NB-1:0] m);
    rel = m; @(negedge clk); rel = '0;
  endtask
  task automatic do_abort(logic [NB-1:0] m);
    abt = m; @(negedge clk); abt = '0;
  endtask
  task automatic pulse_done();
    tx_done = 1; @(negedge clk); tx_done = 0;
  endtask
  task automatic pulse_err();
    tx_err = 1; @(negedge clk); tx_err = 0;
  endtask
  task automatic wait_start(string tag, int exp_idx, logic [DW-1:0] exp_pl);
    int guard = 0;
    while (tx_start !== 1'b1 && guard < 50) begin @(negedge clk); guard++; end
    cmp({tag, " start seen"}, 32'(tx_start), 32'd1);
    cmp({tag, " selected slot"}, 32'(tx_idx), 32'(exp_idx));
    cmp({tag, " selected payload"}, 32'(tx_payload), 32'(exp_pl));
    @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp_en = 1;
    // R1 reset state
    cmp("R1 empty after reset", 32'(empty), 32'h7);
    cmp("R1 ack after reset", 32'(ack), 32'h0);
    cmp("R1 start after reset", 32'(tx_start), 32'h0);

    // Load with bus busy; tie between slots 1 and 2
    load(0, 30, 16'hA0A0);
    load(1, 10, 16'hB1B1);
    load(2, 10, 16'hC2C2);
    do_release(3'b111);
    cmp("R3 release clears empty", 32'(empty), 32'h0);
    repeat (3) @(negedge clk);
    cmp("R5 no start while bus not idle", 32'(n_starts), 32'd0);
    bus_idle = 1;
    wait_start("R4 tie goes to lower index", 1, 16'hB1B1);
    load(1, 0, 16'hDEAD);   // slot 1 is on the wire: ignored
    repeat (3) @(negedge clk);
    cmp("R5 single start while busy", 32'(n_starts), 32'd1);
    cmp("R2 load to busy slot ignored", 32'(tx_payload), 32'hB1B1);
    pulse_done();
    cmp("R6 done sets empty", 32'(empty[1]), 32'd1);
    cmp("R6 done keeps ack low", 32'(ack[1]), 32'd0);
    wait_start("R4 next by priority", 2, 16'hC2C2);
    load(1, 5, 16'hD3D3);
    do_release(3'b010);
    pulse_err();
    cmp("R7 error keeps slot pending", 32'(empty[2]), 32'd0);
    wait_start("R7 reselect after error", 1, 16'hD3D3);
    pulse_done();
    wait_start("R7 retry of failed slot", 2, 16'hC2C2);
    pulse_done();
    wait_start("R4 last pending", 0, 16'hA0A0);
    do_abort(3'b001);
    @(negedge clk);
    cmp("R9 abort on air deferred empty", 32'(empty[0]), 32'd0);
    cmp("R9 abort on air deferred ack", 32'(ack[0]), 32'd0);
    pulse_done();
    cmp("R9 done wins over abort empty", 32'(empty[0]), 32'd1);
    cmp("R9 done wins over abort ack", 32'(ack[0]), 32'd0);

    // Abort of a waiting slot
    bus_idle = 0;
    load(0, 1, 16'hE4E4);
    do_release(3'b001);
    do_abort(3'b001);
    @(negedge clk);
    cmp("R8 abort frees slot", 32'(empty[0]), 32'd1);
    cmp("R8 abort sets ack", 32'(ack[0]), 32'd1);
    cmp("R10 irq unmasked slot", 32'(irq[0]), 32'd1);
    do_abort(3'b100);
    @(negedge clk);
    cmp("R8 abort of empty slot ignored", 32'(ack[2]), 32'd0);
    do_release(3'b001);
    cmp("R3 release clears ack", 32'(ack[0]), 32'd0);
    cmp("R3 release clears empty", 32'(empty[0]), 32'd0);
    cmp("R10 irq masking", 32'(irq), 32'h4);

    // Abort during transmission ending in error
    bus_idle = 1;
    wait_start("R4 single pending", 0, 16'hE4E4);
    do_abort(3'b001);
    @(negedge clk);
    cmp("R9 held while on air", 32'(ack[0]), 32'd0);
    s0 = n_starts;
    pulse_err();
    @(negedge clk);
    cmp("R9 abort granted after error empty", 32'(empty[0]), 32'd1);
    cmp("R9 abort granted after error ack", 32'(ack[0]), 32'd1);
    repeat (3) @(negedge clk);
    cmp("R9 aborted slot not restarted", 32'(n_starts), 32'(s0));

    irq_en = 3'b010;
    @(negedge clk);
    cmp("R10 irq follows enable", 32'(irq), 32'h2);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule